// File: doc/BRIEF.md
# Fifth-Order CIC Decimator with Output Scaling

This block takes a one-bit pulse-density stream per channel and reduces it to multi-bit samples at the input rate divided by a programmable factor M. Each input bit counts as +1 or -1. Five integrator stages run at the input rate, and five comb stages run once every M accepted inputs. The DC gain is therefore M^5. A programmable scaling stage then shifts that gain into a 22-bit signed word for a downstream FIR stage, and clamps anything that does not fit.

Two channels, A and B, share one decimation counter. Channel A always runs while the block is started. Channel B runs only when stereo operation was chosen at start and its own start input is high. The decimation field holds M-1. The shift field holds the wanted right shift plus 8, so left shifts of up to 8 can be encoded.

Control sits in a two-state machine. ST_HALT clears every accumulator, the counter and the outputs. ST_RUN filters. The start transition ST_HALT to ST_RUN is taken when soft reset is low, start_a is high and the requested M is legal. The factor, the shift code and the stereo choice are captured on that transition. The stop transition ST_RUN to ST_HALT is taken when soft reset rises or start_a falls. The normal bring-up holds soft reset and mute high, releases soft reset together with start_a, and then releases mute.

Top module: `cic5_decim`

## Requirements
- R1: Every output sample equals the input sequence convolved with the coefficients of (1 + z^-1 + ... + z^-(M-1))^5, evaluated at the input that completes the decimation period. Input bit 1 counts as +1 and bit 0 as -1. Inputs before the start count as 0.
- R2: M is comb_cnt+1. out_valid is high for exactly one cycle, in the cycle after every M-th accepted input since the start transition, and at no other time.
- R3: The raw result is shifted by shift_code-8. An arithmetic right shift is used when this value is zero or above, and a left shift of 8-shift_code is used when it is below zero.
- R4: After the shift, a value above 2^21-1 becomes 2^21-1 and a value below -2^21 becomes -2^21. Values in range pass through unchanged.
- R5: While mute is high, every output sample is 0. out_valid keeps its normal cadence.
- R6: When stereo is 0 at the start transition (mono), out_b is 0 throughout the run. When stereo is 1, channel B is filtered independently, by the rule of R1.
- R7: With stereo chosen, out_b is 0 while start_b is low. Channel B's history restarts from the first input accepted after start_b rises.
- R8: When soft reset is high, or start_a is low, the block goes to ST_HALT. The following happen from the next cycle on:
  - out_valid, out_a and out_b are 0;
  - a decimation period completing in the same cycle as soft reset produces no output;
  - a later start begins with empty history.
- R9: A requested M (comb_cnt+1) outside M_MIN..M_MAX (defaults 2..32) keeps the block in ST_HALT, and no output is produced.
- R10: Changes to comb_cnt, shift_code and stereo while in ST_RUN have no effect until the next start transition.
- R11: A cycle with pdm_valid low leaves the filter state and the counter unchanged, and produces no out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous stop and clear |
| mute | input | 1 | Force output samples to zero |
| start_a | input | 1 | Run request; also enables channel A |
| start_b | input | 1 | Channel B enable (stereo only) |
| stereo | input | 1 | 1 = two channels, 0 = channel A only; captured at start |
| comb_cnt | input | 5 | Decimation factor minus one; captured at start |
| shift_code | input | 5 | Output shift plus 8; captured at start |
| pdm_valid | input | 1 | Input bits present this cycle |
| pdm_a | input | 1 | Channel A input bit |
| pdm_b | input | 1 | Channel B input bit |
| out_valid | output | 1 | Output sample strobe |
| out_a | output | 22 | Channel A sample, signed |
| out_b | output | 22 | Channel B sample, signed |

## Verification
The cycle of interest is one where soft reset is raised on the very input that completes a decimation period. The stop must win: no out_valid, zero outputs, and fresh history after the next start.

The bench provokes this by feeding M-1 inputs and then driving the M-th input together with soft reset. It judges the result by the strobe and data in the following cycle, and by a full comparison of the next run against the arithmetic model. Mute changing on a tick input, and start_b rising mid-period, are treated the same way: the strobe and data of the tick are compared against the bench's own convolution.

// File: rtl/cic_pkg.sv
package cic_pkg;
    localparam int CIC_ORDER = 5;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } cic_state_e;
endpackage

// File: rtl/cic_integ.sv
module cic_integ #(
    parameter int N = 5,
    parameter int W = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic                bit_in,
    output logic signed [W-1:0] sum_out
);
    logic signed [W-1:0] acc_q [N];
    logic signed [W-1:0] nxt   [N];
    logic signed [W-1:0] step;
    logic signed [W-1:0] run;

    // bit 1 maps to +1, bit 0 maps to -1
    assign step = bit_in ? {{(W-1){1'b0}}, 1'b1} : {W{1'b1}};

    always_comb begin
        run = step;
        for (int k = 0; k < N; k++) begin
            run    = acc_q[k] + run;
            nxt[k] = run;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) acc_q[k] <= '0;
        end else if (clr) begin
            for (int k = 0; k < N; k++) acc_q[k] <= '0;
        end else if (en) begin
            for (int k = 0; k < N; k++) acc_q[k] <= nxt[k];
        end
    end

    assign sum_out = nxt[N-1];

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (acc_q[0] == '0)); // R8
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
    parameter int N = 5,
    parameter int W = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic signed [W-1:0] x_in,
    output logic signed [W-1:0] y_out
);
    logic signed [W-1:0] dly_q [N];
    logic signed [W-1:0] dif   [N];
    logic signed [W-1:0] run;

    always_comb begin
        run = x_in;
        for (int k = 0; k < N; k++) begin
            dif[k] = run - dly_q[k];
            run    = dif[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) dly_q[k] <= '0;
        end else if (clr) begin
            for (int k = 0; k < N; k++) dly_q[k] <= '0;
        end else if (en) begin
            dly_q[0] <= x_in;
            for (int k = 1; k < N; k++) dly_q[k] <= dif[k-1];
        end
    end

    assign y_out = dif[N-1];
endmodule

// File: rtl/cic_scale.sv
module cic_scale #(
    parameter int IN_W   = 31,
    parameter int OUT_W  = 22,
    parameter int SH_W   = 5,
    parameter int SH_OFF = 8
) (
    input  logic signed [IN_W-1:0]  x_in,
    input  logic        [SH_W-1:0]  code,
    output logic signed [OUT_W-1:0] y_out
);
    localparam int WIDE = IN_W + SH_OFF;

    logic signed [WIDE-1:0] ext;
    logic signed [WIDE-1:0] shd;
    logic        [SH_W-1:0] amt;
    logic                   fits;

    always_comb begin
        ext = {{SH_OFF{x_in[IN_W-1]}}, x_in};
        if (code >= SH_W'(SH_OFF)) begin
            amt = code - SH_W'(SH_OFF);
            shd = ext >>> amt;
        end else begin
            amt = SH_W'(SH_OFF) - code;
            shd = ext <<< amt;
        end
        fits = (&shd[WIDE-1:OUT_W-1]) | ~(|shd[WIDE-1:OUT_W-1]);
        if (fits) begin
            y_out = shd[OUT_W-1:0];
        end else if (shd[WIDE-1]) begin
            y_out = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            y_out = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/cic5_decim.sv
module cic5_decim
    import cic_pkg::*;
#(
    parameter int M_MIN  = 2,
    parameter int M_MAX  = 32,
    parameter int OUT_W  = 22,
    parameter int SH_W   = 5,
    parameter int SH_OFF = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic                     mute,
    input  logic                     start_a,
    input  logic                     start_b,
    input  logic                     stereo,
    input  logic [$clog2(M_MAX)-1:0] comb_cnt,
    input  logic [SH_W-1:0]          shift_code,
    input  logic                     pdm_valid,
    input  logic                     pdm_a,
    input  logic                     pdm_b,
    output logic                     out_valid,
    output logic [OUT_W-1:0]         out_a,
    output logic [OUT_W-1:0]         out_b
);
    localparam int CNT_W = $clog2(M_MAX);
    localparam int ACC_W = CIC_ORDER * $clog2(M_MAX + 1) + 1;
    localparam int NCH   = 2;

    cic_state_e state_q, state_d;

    logic [CNT_W-1:0] mcnt_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SH_W-1:0]  code_q;
    logic             stereo_q;
    int               m_req;
    logic             cfg_ok;
    logic             run_go;
    logic             acc_en;
    logic             tick;
    logic             b_act;
    logic [NCH-1:0]   pdm_bits;
    logic [NCH-1:0]   clr_v;
    logic signed [OUT_W-1:0] scaled [NCH];

    always_comb begin
        m_req  = int'(comb_cnt) + 1;
        cfg_ok = (m_req >= M_MIN) && (m_req <= M_MAX);
    end

    assign run_go   = (state_q == ST_RUN) && !soft_rst && start_a;
    assign acc_en   = run_go && pdm_valid;
    assign tick     = acc_en && (cnt_q == mcnt_q);
    assign b_act    = stereo_q && start_b;
    assign pdm_bits = {pdm_b, pdm_a};
    assign clr_v    = {(!run_go || !b_act), !run_go};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (!soft_rst && start_a && cfg_ok) state_d = ST_RUN;
            ST_RUN:  if (soft_rst || !start_a)           state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // state register, captured configuration and decimation counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_HALT;
            mcnt_q   <= '0;
            code_q   <= '0;
            stereo_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HALT && state_d == ST_RUN) begin
                mcnt_q   <= comb_cnt;
                code_q   <= shift_code;
                stereo_q <= stereo;
            end
            if (!run_go) begin
                cnt_q <= '0;
            end else if (pdm_valid) begin
                cnt_q <= tick ? '0 : cnt_q + 1'b1;
            end
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic signed [ACC_W-1:0] integ_y;
        logic signed [ACC_W-1:0] comb_y;

        cic_integ #(.N(CIC_ORDER), .W(ACC_W)) i_integ (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr_v[ch]),
            .en      (acc_en),
            .bit_in  (pdm_bits[ch]),
            .sum_out (integ_y)
        );

        cic_comb #(.N(CIC_ORDER), .W(ACC_W)) i_comb (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_v[ch]),
            .en    (tick),
            .x_in  (integ_y),
            .y_out (comb_y)
        );

        cic_scale #(.IN_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W), .SH_OFF(SH_OFF)) i_scale (
            .x_in  (comb_y),
            .code  (code_q),
            .y_out (scaled[ch])
        );
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_a     <= '0;
            out_b     <= '0;
        end else if (!run_go) begin
            out_valid <= 1'b0;
            out_a     <= '0;
            out_b     <= '0;
        end else begin
            out_valid <= tick;
            if (tick) begin
                out_a <= mute ? '0 : scaled[0];
                out_b <= (mute || !b_act) ? '0 : scaled[1];
            end
        end
    end

    AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pdm_valid)); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= mcnt_q); // R2
    AST_MUTE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mute) && out_valid) |-> (out_a == '0 && out_b == '0)); // R5
    AST_MONO_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !stereo_q) |-> (out_b == '0)); // R6
    AST_SRST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> !out_valid); // R8
    AST_BAD_M_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !cfg_ok) |=> (state_q == ST_HALT)); // R9
endmodule

// File: tb/test_cic5_decim.sv
module test_cic5_decim;
    localparam int OUT_W  = 22;
    localparam int SH_OFF = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, soft_rst, mute, start_a, start_b, stereo;
    logic [4:0]  comb_cnt, shift_code;
    logic        pdm_valid, pdm_a, pdm_b;
    logic        out_valid;
    logic [21:0] out_a, out_b;

    cic5_decim i_cic5_decim (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mute(mute),
        .start_a(start_a), .start_b(start_b), .stereo(stereo),
        .comb_cnt(comb_cnt), .shift_code(shift_code),
        .pdm_valid(pdm_valid), .pdm_a(pdm_a), .pdm_b(pdm_b),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
    );

    int      checks = 0;
    int      errors = 0;
    bit      done = 0;
    int      xa [0:1023];
    int      xb [0:1023];
    longint  h  [0:255];
    int      n_in;
    int      cur_m;
    int      cur_code;
    bit      b_live;
    bit      mute_live;
    logic [15:0] lfsr = 16'hACE1;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rand_bit(output bit b);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        b = lfsr[0];
    endtask

    task automatic build_h(input int m);
        longint t [0:255];
        for (int i = 0; i < 256; i++) h[i] = (i < m) ? 1 : 0;
        repeat (4) begin
            for (int i = 0; i < 256; i++) begin
                t[i] = 0;
                for (int j = 0; j < m; j++) if (i - j >= 0) t[i] += h[i-j];
            end
            for (int i = 0; i < 256; i++) h[i] = t[i];
        end
    endtask

    function automatic longint raw_of(input bit chb);
        longint s = 0;
        for (int j = 0; j <= 5 * cur_m - 5; j++) begin
            int idx = n_in - j;
            if (idx >= 1) s += h[j] * longint'(chb ? xb[idx] : xa[idx]);
        end
        return s;
    endfunction

    function automatic longint scale_of(input longint r, input int code);
        longint v;
        int s = code - SH_OFF;
        longint hi = (longint'(1) <<< (OUT_W - 1)) - 1;
        longint lo = -(longint'(1) <<< (OUT_W - 1));
        v = (s >= 0) ? (r >>> s) : (r <<< (-s));
        if (v > hi) v = hi;
        if (v < lo) v = lo;
        return v;
    endfunction

    // drive one cycle at a falling edge, sample at the next falling edge
    task automatic feed(input bit v, input bit a, input bit b, input string tv, input string td);
        bit     expv;
        longint ea, eb;
        expv = 0;
        pdm_valid = v; pdm_a = a; pdm_b = b;
        @(posedge clk); @(negedge clk);
        if (v) begin
            n_in++;
            xa[n_in] = a ? 1 : -1;
            xb[n_in] = b_live ? (b ? 1 : -1) : 0;
            expv = (n_in % cur_m == 0);
        end
        chk(tv, longint'(out_valid), longint'(expv));
        if (expv && out_valid) begin
            ea = mute_live ? 0 : scale_of(raw_of(1'b0), cur_code);
            eb = (mute_live || !b_live) ? 0 : scale_of(raw_of(1'b1), cur_code);
            chk(td, longint'($signed(out_a)), ea);
            chk(td, longint'($signed(out_b)), eb);
        end
        pdm_valid = 0;
    endtask

    task automatic restart(input int m, input int code, input bit st, input bit sb);
        soft_rst = 1; start_a = 1;
        @(posedge clk); @(negedge clk);
        comb_cnt = 5'(m - 1); shift_code = 5'(code); stereo = st; start_b = sb;
        soft_rst = 0; mute = 0;
        @(posedge clk); @(negedge clk);
        cur_m = m; cur_code = code; b_live = st && sb; mute_live = 0; n_in = 0;
        build_h(m);
    endtask

    function automatic int bitlen(input longint v);
        int n = 0;
        while (v != 0) begin v = v >>> 1; n++; end
        return n;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        bit a, b;
        rst_n = 0; soft_rst = 1; mute = 1; start_a = 0; start_b = 0; stereo = 0;
        comb_cnt = 5'd3; shift_code = 5'd8; pdm_valid = 0; pdm_a = 0; pdm_b = 0;
        cur_m = 4; cur_code = 8; n_in = 0; b_live = 0; mute_live = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8: reset state
        chk("R8", longint'(out_valid), 0);
        chk("R8", longint'(out_a), 0);
        chk("R8", longint'(out_b), 0);

        // R1 R2 R11: sweep every legal factor, stereo, with idle gaps
        for (int m = 2; m <= 32; m++) begin
            int code = bitlen(longint'(m) ** 5) - OUT_W + SH_OFF;
            int fed = 0;
            int k = 0;
            if (code < 0) code = 0;
            restart(m, code, 1, 1);
            while (fed < 10 * m) begin
                if (k % 7 == 6) begin
                    feed(0, 0, 0, "R11", "R11");
                end else begin
                    rand_bit(a); rand_bit(b);
                    feed(1, a, b, "R2", "R1");
                    fed++;
                end
                k++;
            end
        end

        // R3 R4: every shift code, constant ones on A and zeros on B
        for (int code = 0; code < 32; code++) begin
            restart(8, code, 1, 1);
            for (int i = 0; i < 48; i++) feed(1, 1, 0, "R2", (code < 3) ? "R4" : "R3");
        end

        // R5: mute mid-run, strobes continue
        restart(4, 10, 1, 1);
        for (int i = 0; i < 48; i++) begin
            if (i == 11) begin mute = 1; mute_live = 1; end
            if (i == 27) begin mute = 0; mute_live = 0; end
            rand_bit(a); rand_bit(b);
            feed(1, a, b, "R5", "R5");
        end

        // R6: mono
        restart(5, 9, 0, 1);
        for (int i = 0; i < 40; i++) begin
            rand_bit(a); rand_bit(b);
            feed(1, a, b, "R6", "R6");
        end

        // R7: channel B enabled mid-period
        restart(5, 9, 1, 0);
        for (int i = 0; i < 60; i++) begin
            if (i == 22) begin start_b = 1; b_live = 1; end
            rand_bit(a); rand_bit(b);
            feed(1, a, b, "R7", "R7");
        end

        // R8: soft reset on the input that completes a period
        restart(6, 9, 1, 1);
        for (int i = 0; i < 5; i++) begin
            rand_bit(a); rand_bit(b);
            feed(1, a, b, "R8", "R8");
        end
        soft_rst = 1; pdm_valid = 1; pdm_a = 1; pdm_b = 1;
        @(posedge clk); @(negedge clk);
        pdm_valid = 0;
        chk("R8", longint'(out_valid), 0);
        chk("R8", longint'(out_a), 0);
        chk("R8", longint'(out_b), 0);
        restart(6, 9, 1, 1);
        for (int i = 0; i < 36; i++) begin
            rand_bit(a); rand_bit(b);
            feed(1, a, b, "R8", "R8");
        end

        // R9: illegal factor (comb_cnt 0 means M = 1) stays halted
        soft_rst = 1;
        @(posedge clk); @(negedge clk);
        comb_cnt = 5'd0; soft_rst = 0; start_a = 1;
        @(posedge clk); @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            pdm_valid = 1; pdm_a = 1; pdm_b = 1;
            @(posedge clk); @(negedge clk);
            chk("R9", longint'(out_valid), 0);
        end
        pdm_valid = 0;

        // R10: configuration changes during a run are ignored
        restart(4, 10, 1, 1);
        for (int i = 0; i < 40; i++) begin
            if (i == 9) begin comb_cnt = 5'd9; shift_code = 5'd0; stereo = 0; end
            rand_bit(a); rand_bit(b);
            feed(1, a, b, "R10", "R10");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule